// File: doc/BRIEF.md
# Shift and Rotate Unit

This unit moves an operand of 8, 16 or 32 bits left or right by one or two bit positions. It offers zero-filling and sign-preserving shifts, rotates, and rotates through the carry flag. Along with the new value it produces the negative, zero, overflow and carry condition flags. A datapath issues one operation per cycle with a valid strobe. One cycle later the unit returns the zero-extended result, a packed 4-bit flag word and a matching valid.

Each size has its own lane. A lane is built from two single-position stages in a chain. A two-position operation is the one-position operation applied twice, and the carry out of the first stage feeds the second. The selected size picks the lane. The flag logic then looks at the sign bit of that size.

Top module: `shift_rot_unit`

## Requirements
- R1: `size_i` selects the width: 0 gives 8 bits, 1 gives 16 bits, 2 or 3 gives 32 bits. Operand bits above the selected width do not affect any output, and result bits above the selected width are zero.
- R2: `cnt2_i` = 0 moves the operand by one position and `cnt2_i` = 1 moves it by two. For a move by two, C holds the second bit that leaves the operand.
- R3: Logical left (`op_i` = 0) fills the LSB end with zeros, and C takes the bit leaving the MSB end. Logical right (`op_i` = 1) fills the MSB end with zeros, and C takes the bit leaving the LSB end.
- R4: Arithmetic right (`op_i` = 3) copies the sign bit into each vacated MSB position, and C takes the bit leaving the LSB end.
- R5: Arithmetic left (`op_i` = 2) gives the same result and C as logical left. V is set when the top count+1 bits of the operand are not all equal, meaning the sign changes during the shift.
- R6: Every operation other than arithmetic left clears V.
- R7: Rotate left (`op_i` = 4) and rotate right (`op_i` = 5) move each bit that leaves one end into the other end. C is a copy of the last bit moved.
- R8: Rotate left through carry (`op_i` = 6) and right through carry (`op_i` = 7) treat C as one extra bit. The old C enters the vacated end, and the bit leaving the other end becomes the new C.
- R9: N is the result MSB at the selected width. Z is 1 exactly when the result at that width is zero.
- R10: `ccr_o` packs N in bit 3, Z in bit 2, V in bit 1 and C in bit 0.
- R11: The result and flags appear on the clock edge after the one that sampled `valid_i` = 1, with `valid_o` = 1. In a cycle with `valid_i` = 0, the next edge drives `valid_o` to 0, and `result_o` and `ccr_o` keep their values.
- R12: During reset, `valid_o`, `result_o` and `ccr_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| size_i | input | 2 | Operand width select |
| op_i | input | 3 | Operation select |
| cnt2_i | input | 1 | Move by two positions when set |
| carry_i | input | 1 | Current carry flag |
| operand_i | input | 32 | Operand, low bits used at smaller widths |
| valid_o | output | 1 | Result valid |
| result_o | output | 32 | Result, zero-extended |
| ccr_o | output | 4 | Flags: N, Z, V, C |

## Verification
A wrong lane choice or a mis-wired stage shows up in the very next `valid_o` cycle. It appears as a wrong result or as a carry taken from the wrong end or from the first stage instead of the second. A stale or sticky overflow term appears one cycle after an operation that is not arithmetic left, because V reads 1 there. Flags derived from the wrong width show up as an N or Z that disagrees with the visible result. Leaking upper operand bits show up as non-zero result bits above the selected width. In every case the fault is visible at the first affected issue.

// File: rtl/shift_rot_pkg.sv
package shift_rot_pkg;

  localparam int unsigned DATA_W    = 32;
  localparam int unsigned NUM_LANES = 3;
  localparam int unsigned CCR_W     = 4;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WALT = 2'd3
  } size_e;

  typedef enum logic [2:0] {
    OP_SHL = 3'd0,
    OP_SHR = 3'd1,
    OP_SAL = 3'd2,
    OP_SAR = 3'd3,
    OP_ROL = 3'd4,
    OP_ROR = 3'd5,
    OP_RCL = 3'd6,
    OP_RCR = 3'd7
  } op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } ccr_t;

  function automatic int unsigned lane_width(int unsigned idx);
    return 32'd8 << idx;
  endfunction

  function automatic int unsigned lane_index(size_e sz);
    case (sz)
      SZ_BYTE: return 0;
      SZ_HALF: return 1;
      default: return 2;
    endcase
  endfunction

endpackage

// File: rtl/shr_step.sv
module shr_step
  import shift_rot_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] x_i,
  input  op_e          op_i,
  input  logic         c_i,
  output logic [W-1:0] y_o,
  output logic         c_o,
  output logic         v_o
);

  localparam int unsigned MSB = W - 1;

  always_comb begin
    y_o = x_i;
    c_o = 1'b0;
    v_o = 1'b0;
    case (op_i)
      OP_SHL: begin
        y_o = {x_i[MSB-1:0], 1'b0};
        c_o = x_i[MSB];
      end
      OP_SAL: begin
        y_o = {x_i[MSB-1:0], 1'b0};
        c_o = x_i[MSB];
        v_o = x_i[MSB] ^ x_i[MSB-1];  // sign flips on this step
      end
      OP_SHR: begin
        y_o = {1'b0, x_i[MSB:1]};
        c_o = x_i[0];
      end
      OP_SAR: begin
        y_o = {x_i[MSB], x_i[MSB:1]};
        c_o = x_i[0];
      end
      OP_ROL: begin
        y_o = {x_i[MSB-1:0], x_i[MSB]};
        c_o = x_i[MSB];
      end
      OP_ROR: begin
        y_o = {x_i[0], x_i[MSB:1]};
        c_o = x_i[0];
      end
      OP_RCL: begin
        y_o = {x_i[MSB-1:0], c_i};
        c_o = x_i[MSB];
      end
      OP_RCR: begin
        y_o = {c_i, x_i[MSB:1]};
        c_o = x_i[0];
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/shr_lane.sv
module shr_lane
  import shift_rot_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] x_i,
  input  op_e          op_i,
  input  logic         cnt2_i,
  input  logic         c_i,
  output logic [W-1:0] res_o,
  output logic         c_o,
  output logic         v_o
);

  logic [W-1:0] y1, y2;
  logic         c1, c2, v1, v2;

  shr_step #(.W(W)) u_step1 (
    .x_i (x_i),
    .op_i(op_i),
    .c_i (c_i),
    .y_o (y1),
    .c_o (c1),
    .v_o (v1)
  );

  // second stage sees the carry produced by the first
  shr_step #(.W(W)) u_step2 (
    .x_i (y1),
    .op_i(op_i),
    .c_i (c1),
    .y_o (y2),
    .c_o (c2),
    .v_o (v2)
  );

  always_comb begin
    if (cnt2_i) begin
      res_o = y2;
      c_o   = c2;
      v_o   = v1 | v2;
    end else begin
      res_o = y1;
      c_o   = c1;
      v_o   = v1;
    end
  end

endmodule

// File: rtl/shr_flags.sv
module shr_flags
  import shift_rot_pkg::*;
(
  input  logic [DATA_W-1:0] res_i,
  input  size_e             size_i,
  output logic              n_o,
  output logic              z_o
);

  logic [DATA_W-1:0] mask;

  always_comb begin
    case (size_i)
      SZ_BYTE: begin
        mask = DATA_W'(32'h0000_00ff);
        n_o  = res_i[7];
      end
      SZ_HALF: begin
        mask = DATA_W'(32'h0000_ffff);
        n_o  = res_i[15];
      end
      default: begin
        mask = '1;
        n_o  = res_i[DATA_W-1];
      end
    endcase
    z_o = ~|(res_i & mask);
  end

endmodule

// File: rtl/shift_rot_unit.sv
module shift_rot_unit
  import shift_rot_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        size_i,
  input  logic [2:0]        op_i,
  input  logic              cnt2_i,
  input  logic              carry_i,
  input  logic [DATA_W-1:0] operand_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic [CCR_W-1:0]  ccr_o
);

  size_e size_s;
  op_e   op_s;

  assign size_s = size_e'(size_i);
  assign op_s   = op_e'(op_i);

  logic [DATA_W-1:0] lane_res [NUM_LANES];
  logic              lane_c   [NUM_LANES];
  logic              lane_v   [NUM_LANES];

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    localparam int unsigned LW = lane_width(g);
    logic [LW-1:0] res_w;

    shr_lane #(.W(LW)) u_lane (
      .x_i   (operand_i[LW-1:0]),
      .op_i  (op_s),
      .cnt2_i(cnt2_i),
      .c_i   (carry_i),
      .res_o (res_w),
      .c_o   (lane_c[g]),
      .v_o   (lane_v[g])
    );

    assign lane_res[g] = DATA_W'(res_w);
  end

  logic [DATA_W-1:0] sel_res;
  logic              sel_c, sel_v, flag_n, flag_z;
  ccr_t              ccr_d;

  always_comb begin
    sel_res = lane_res[2];
    sel_c   = lane_c[2];
    sel_v   = lane_v[2];
    case (lane_index(size_s))
      0: begin
        sel_res = lane_res[0];
        sel_c   = lane_c[0];
        sel_v   = lane_v[0];
      end
      1: begin
        sel_res = lane_res[1];
        sel_c   = lane_c[1];
        sel_v   = lane_v[1];
      end
      default: ;
    endcase
  end

  shr_flags u_flags (
    .res_i (sel_res),
    .size_i(size_s),
    .n_o   (flag_n),
    .z_o   (flag_z)
  );

  assign ccr_d = '{n: flag_n, z: flag_z, v: sel_v, c: sel_c};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      ccr_o    <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o <= sel_res;
        ccr_o    <= ccr_d;
      end
    end
  end

endmodule

// File: rtl/shift_rot_unit_chk.sv
module shift_rot_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [1:0]  size_i,
  input logic [2:0]  op_i,
  input logic        valid_o,
  input logic [31:0] result_o,
  input logic [3:0]  ccr_o
);

  assert_valid_follows_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  assert_idle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(result_o) && $stable(ccr_o)));

  assert_upper_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && size_i == 2'd0) |=> (result_o[31:8] == 24'd0));

  assert_upper_zero_half_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && size_i == 2'd1) |=> (result_o[31:16] == 16'd0));

  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i != 3'd2) |=> !ccr_o[1]);

  assert_zero_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (ccr_o[2] == (result_o == 32'd0)));

  assert_sign_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (ccr_o[3] == ($past(size_i) == 2'd0 ? result_o[7] :
                              $past(size_i) == 2'd1 ? result_o[15] : result_o[31])));

endmodule

bind shift_rot_unit shift_rot_unit_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .size_i  (size_i),
  .op_i    (op_i),
  .valid_o (valid_o),
  .result_o(result_o),
  .ccr_o   (ccr_o)
);

// File: tb/shift_rot_unit_bench.sv
module shift_rot_unit_bench;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  size_i = '0;
  logic [2:0]  op_i = '0;
  logic        cnt2_i = 1'b0;
  logic        carry_i = 1'b0;
  logic [31:0] operand_i = '0;
  logic        valid_o;
  logic [31:0] result_o;
  logic [3:0]  ccr_o;

  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  shift_rot_unit u_shift_rot_unit (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .size_i   (size_i),
    .op_i     (op_i),
    .cnt2_i   (cnt2_i),
    .carry_i  (carry_i),
    .operand_i(operand_i),
    .valid_o  (valid_o),
    .result_o (result_o),
    .ccr_o    (ccr_o)
  );

  // returns {ccr, result}
  function automatic logic [35:0] ref_model(logic [2:0] op, logic [1:0] sz, logic two,
                                            logic cin, logic [31:0] x);
    int w;
    logic [31:0] m, v;
    logic c, vf, msb, lsb, nxt;
    w  = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    m  = (w == 32) ? 32'hffff_ffff : ((32'd1 << w) - 32'd1);
    v  = x & m;
    c  = cin;
    vf = 1'b0;
    for (int i = 0; i < (two ? 2 : 1); i++) begin
      msb = v[w-1];
      lsb = v[0];
      case (op)
        3'd0, 3'd2: begin
          if (op == 3'd2 && (v[w-1] != v[w-2])) vf = 1'b1;
          v = (v << 1) & m; c = msb;
        end
        3'd1: begin v = v >> 1; c = lsb; end
        3'd3: begin v = (v >> 1) | ({31'd0, msb} << (w - 1)); c = lsb; end
        3'd4: begin v = ((v << 1) | {31'd0, msb}) & m; c = msb; end
        3'd5: begin v = (v >> 1) | ({31'd0, lsb} << (w - 1)); c = lsb; end
        3'd6: begin nxt = msb; v = ((v << 1) | {31'd0, c}) & m; c = nxt; end
        default: begin nxt = lsb; v = (v >> 1) | ({31'd0, c} << (w - 1)); c = nxt; end
      endcase
    end
    return {v[w-1], (v == 32'd0), vf, c, v};
  endfunction

  function automatic string op_tag(logic [2:0] op);
    case (op)
      3'd0, 3'd1: return "R3";
      3'd2:       return "R5";
      3'd3:       return "R4";
      3'd4, 3'd5: return "R7";
      default:    return "R8";
    endcase
  endfunction

  task automatic check_out(logic [31:0] exp_res, logic [3:0] exp_ccr, string tag);
    checks++;
    if (valid_o !== 1'b1 || result_o !== exp_res || ccr_o !== exp_ccr) begin
      errors++;
      $display("FAIL %s: valid=%b result=%h ccr=%b expected valid=1 result=%h ccr=%b",
               tag, valid_o, result_o, ccr_o, exp_res, exp_ccr);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the capture
  task automatic issue(logic [2:0] op, logic [1:0] sz, logic two, logic cin,
                       logic [31:0] x);
    valid_i   = 1'b1;
    op_i      = op;
    size_i    = sz;
    cnt2_i    = two;
    carry_i   = cin;
    operand_i = x;
    @(negedge clk_i);
  endtask

  task automatic directed(logic [2:0] op, logic [1:0] sz, logic two, logic cin,
                          logic [31:0] x, logic [31:0] exp_res, logic [3:0] exp_ccr,
                          string tag);
    issue(op, sz, two, cin, x);
    check_out(exp_res, exp_ccr, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL R11: watchdog expired, actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] held_res;
    logic [3:0]  held_ccr;
    logic [35:0] exp;
    logic [2:0]  rop;
    logic [1:0]  rsz;
    logic        r2, rc;
    logic [31:0] rx;

    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    // R12: outputs in reset
    checks++;
    if (valid_o !== 1'b0 || result_o !== 32'd0 || ccr_o !== 4'd0) begin
      errors++;
      $display("FAIL R12: valid=%b result=%h ccr=%b expected 0/0/0", valid_o, result_o, ccr_o);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);

    directed(3'd0, 2'd0, 1'b0, 1'b0, 32'h0000_0081, 32'h0000_0002, 4'b0001, "R3");
    directed(3'd0, 2'd0, 1'b1, 1'b0, 32'h0000_0040, 32'h0000_0000, 4'b0101, "R2");
    directed(3'd3, 2'd1, 1'b1, 1'b0, 32'h0000_8001, 32'h0000_e000, 4'b1000, "R4");
    directed(3'd2, 2'd2, 1'b0, 1'b0, 32'h4000_0000, 32'h8000_0000, 4'b1010, "R5");
    directed(3'd2, 2'd0, 1'b1, 1'b0, 32'h0000_0020, 32'h0000_0080, 4'b1010, "R5");
    directed(3'd6, 2'd0, 1'b0, 1'b1, 32'h0000_0080, 32'h0000_0001, 4'b0001, "R8");
    directed(3'd6, 2'd0, 1'b1, 1'b1, 32'h0000_0080, 32'h0000_0003, 4'b0000, "R8");
    directed(3'd7, 2'd1, 1'b0, 1'b1, 32'h0000_0001, 32'h0000_8000, 4'b1001, "R8");
    directed(3'd5, 2'd2, 1'b0, 1'b0, 32'h0000_0001, 32'h8000_0000, 4'b1001, "R7");
    directed(3'd1, 2'd0, 1'b0, 1'b0, 32'hffff_ff00, 32'h0000_0000, 4'b0100, "R1");
    directed(3'd0, 2'd1, 1'b0, 1'b0, 32'hffff_c001, 32'h0000_8002, 4'b1001, "R1");
    directed(3'd5, 2'd0, 1'b0, 1'b0, 32'h0000_00c0, 32'h0000_0060, 4'b0000, "R6");
    directed(3'd2, 2'd1, 1'b1, 1'b0, 32'h0000_c000, 32'h0000_0000, 4'b0111, "R10");
    directed(3'd3, 2'd2, 1'b1, 1'b0, 32'h8000_0000, 32'he000_0000, 4'b1000, "R9");
    directed(3'd1, 2'd3, 1'b0, 1'b0, 32'h0000_0001, 32'h0000_0000, 4'b0101, "R9");

    // R11: idle cycles keep result and flags, drop valid
    held_res = result_o;
    held_ccr = ccr_o;
    valid_i   = 1'b0;
    operand_i = 32'h1234_5678;
    op_i      = 3'd4;
    repeat (3) @(negedge clk_i);
    checks++;
    if (valid_o !== 1'b0 || result_o !== held_res || ccr_o !== held_ccr) begin
      errors++;
      $display("FAIL R11: valid=%b result=%h ccr=%b expected valid=0 result=%h ccr=%b",
               valid_o, result_o, ccr_o, held_res, held_ccr);
    end

    for (int i = 0; i < 4000; i++) begin
      rop = 3'($urandom);
      rsz = 2'($urandom);
      r2  = 1'($urandom);
      rc  = 1'($urandom);
      rx  = $urandom;
      if (i % 7 == 0) rx = {rx[31:3], 3'b000} ^ 32'hffff_fff8;
      exp = ref_model(rop, rsz, r2, rc, rx);
      issue(rop, rsz, r2, rc, rx);
      check_out(exp[31:0], exp[35:32], op_tag(rop));
    end

    valid_i = 1'b0;
    @(negedge clk_i);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule